// File: doc/BRIEF.md
# Operating Mode and Priority Control Register

This block is the chip's mode control register. While reset is held it samples two strap pins on every clock. The register keeps the level that was present on the last clock before reset is released. From those two bits it derives one of four operating modes: single chip, expanded, bootstrap or test. It sets a boot-ROM enable only when the chip comes out of reset in bootstrap mode.

After reset, software reads and writes the register over a simple select/write-enable bus. Each field has its own write protection. The special-mode bit can only be cleared. The mode-A bit and the internal-read-visibility bit can be changed only while the special-mode bit is set. The 4-bit priority-select field can be changed only while the CPU interrupt-mask input is high. The boot-ROM enable can be changed only by reset.

The register uses a synchronous, active-low reset.

Top module: `opmode_ctl_reg`

## Requirements
- R1: At reset the special bit is loaded with the inverse of `mode_b_pin_i` and the mode-A bit with `mode_a_pin_i`. `mode_o` = {special, mode-A}, where 00 = single chip, 01 = expanded, 10 = bootstrap and 11 = test.
- R2: The pins are sampled on every clock while `rst_ni` is low. The level on the last such clock is kept. Pin changes after reset has been released have no effect.
- R3: A write with data bit 6 = 0 clears the special bit. A write with bit 6 = 1 never sets it.
- R4: The mode-A bit (data bit 5) takes the write data only if the special bit was 1 before the write. Otherwise it keeps its value.
- R5: The read-visibility bit (data bit 4, output `rd_vis_o`) resets to 0. It takes the write data only while the special bit is 1. It is cleared on the clock after any cycle in which the special bit is 0.
- R6: The boot-ROM enable (bit 7) is set by reset only in bootstrap mode and cleared by reset in every other mode. Writes to it are ignored.
- R7: The priority field (bits 3:0) resets to 0101.
- R8: The priority field takes the write data only when `irq_mask_i` is 1 during the write cycle.
- R9: A single write that clears the special bit is checked against the special bit's old value, so it still loads mode-A and read-visibility. In that case read visibility is 1 for exactly one cycle and then returns to 0.
- R10: `rd_data_o` is {boot, special, mode-A, visibility, priority[3:0]} while `sel_i` is 1, whatever the write protection. It is 0 while `sel_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| mode_a_pin_i | input | 1 | Strap pin A |
| mode_b_pin_i | input | 1 | Strap pin B (low selects a special mode) |
| irq_mask_i | input | 1 | CPU interrupt-mask bit |
| sel_i | input | 1 | Register select |
| wr_en_i | input | 1 | Write enable (effective with `sel_i`) |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data |
| mode_o | output | 2 | Decoded operating mode |
| boot_rom_en_o | output | 1 | Boot-ROM enable |
| rd_vis_o | output | 1 | Internal-read-visibility enable |
| prio_sel_o | output | PRIO_W | Priority select |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus and a 4-bit priority field with reset value 0101. With these values every field sits at its fixed bit position, so each check compares a complete byte. Every strap combination is driven through reset, with the pins toggled during and after reset. Each write-protection rule is exercised both in its enabled state and in its locked state, including the one-cycle visibility pulse from a combined write.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
   typedef enum logic [1:0] {
      MODE_SINGLE    = 2'b00,
      MODE_EXPANDED  = 2'b01,
      MODE_BOOTSTRAP = 2'b10,
      MODE_TEST      = 2'b11
   } opmode_e;

   function automatic opmode_e opmode_decode(input logic spec, input logic a);
      return opmode_e'({spec, a});
   endfunction
endpackage

// File: rtl/opmode_wr_guard.sv
module opmode_wr_guard (
   input  logic sel_i,
   input  logic wr_en_i,
   input  logic irq_mask_i,
   input  logic spec_q_i,
   input  logic spec_d_i,
   output logic clr_spec_o,
   output logic ld_a_o,
   output logic ld_vis_o,
   output logic ld_prio_o
);
   logic wr_stb;

   always_comb begin
      wr_stb     = sel_i & wr_en_i;
      clr_spec_o = wr_stb & ~spec_d_i;
      ld_a_o     = wr_stb & spec_q_i;
      ld_vis_o   = wr_stb & spec_q_i;
      ld_prio_o  = wr_stb & irq_mask_i;
   end
endmodule

// File: rtl/opmode_fields.sv
module opmode_fields #(
   parameter int unsigned PRIO_W = 4,
   parameter logic [PRIO_W-1:0] PRIO_RST = 4'b0101
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mode_a_pin_i,
   input  logic              mode_b_pin_i,
   input  logic              irq_mask_i,
   input  logic              clr_spec_i,
   input  logic              ld_a_i,
   input  logic              ld_vis_i,
   input  logic              ld_prio_i,
   input  logic              a_d_i,
   input  logic              vis_d_i,
   input  logic [PRIO_W-1:0] prio_d_i,
   output logic              boot_q_o,
   output logic              spec_q_o,
   output logic              a_q_o,
   output logic              vis_q_o,
   output logic [PRIO_W-1:0] prio_q_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         spec_q_o <= ~mode_b_pin_i;
         a_q_o    <= mode_a_pin_i;
         boot_q_o <= ~mode_b_pin_i & ~mode_a_pin_i;
         vis_q_o  <= 1'b0;
         prio_q_o <= PRIO_RST;
      end else begin
         if (clr_spec_i) spec_q_o <= 1'b0;
         if (ld_a_i)     a_q_o    <= a_d_i;
         if (!spec_q_o)  vis_q_o  <= 1'b0;
         else if (ld_vis_i) vis_q_o <= vis_d_i;
         if (ld_prio_i)  prio_q_o <= prio_d_i;
      end
   end

   logic armed_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni) armed_q <= 1'b0;
      else         armed_q <= 1'b1;
   end

   assert_spec_never_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
      !$past(spec_q_o) |-> !spec_q_o);
   assert_a_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
      !$past(spec_q_o) |-> $stable(a_q_o));
   assert_vis_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
      !$past(spec_q_o) |-> !vis_q_o);
   assert_boot_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
      $stable(boot_q_o));
   assert_prio_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
      !$past(irq_mask_i) |-> $stable(prio_q_o));
endmodule

// File: rtl/opmode_rd_pack.sv
module opmode_rd_pack #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PRIO_W = 4
) (
   input  logic              sel_i,
   input  logic              boot_i,
   input  logic              spec_i,
   input  logic              a_i,
   input  logic              vis_i,
   input  logic [PRIO_W-1:0] prio_i,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam int unsigned FIELD_W = PRIO_W + 4;

   logic [FIELD_W-1:0] fields;
   assign fields = sel_i ? {boot_i, spec_i, a_i, vis_i, prio_i} : '0;

   generate
      if (DATA_W > FIELD_W) begin : g_pad
         assign rd_data_o = {{(DATA_W-FIELD_W){1'b0}}, fields};
      end else begin : g_exact
         assign rd_data_o = fields;
      end
   endgenerate
endmodule

// File: rtl/opmode_ctl_reg.sv
module opmode_ctl_reg #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PRIO_W = 4,
   parameter logic [PRIO_W-1:0] PRIO_RST = 4'b0101
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mode_a_pin_i,
   input  logic              mode_b_pin_i,
   input  logic              irq_mask_i,
   input  logic              sel_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [1:0]        mode_o,
   output logic              boot_rom_en_o,
   output logic              rd_vis_o,
   output logic [PRIO_W-1:0] prio_sel_o
);
   import opmode_pkg::*;

   localparam int unsigned VIS_BIT  = PRIO_W;
   localparam int unsigned A_BIT    = PRIO_W + 1;
   localparam int unsigned SPEC_BIT = PRIO_W + 2;
   localparam int unsigned FIELD_W  = PRIO_W + 4;

   generate
      if (PRIO_W < 1) begin : g_bad_prio
         $error("PRIO_W must be at least 1");
      end
      if (DATA_W < FIELD_W) begin : g_bad_data
         $error("DATA_W too narrow for the register fields");
      end
   endgenerate

   logic clr_spec, ld_a, ld_vis, ld_prio;
   logic boot_q, spec_q, a_q, vis_q;
   logic [PRIO_W-1:0] prio_q;

   opmode_wr_guard u_guard (
      .sel_i      (sel_i),
      .wr_en_i    (wr_en_i),
      .irq_mask_i (irq_mask_i),
      .spec_q_i   (spec_q),
      .spec_d_i   (wr_data_i[SPEC_BIT]),
      .clr_spec_o (clr_spec),
      .ld_a_o     (ld_a),
      .ld_vis_o   (ld_vis),
      .ld_prio_o  (ld_prio)
   );

   opmode_fields #(.PRIO_W(PRIO_W), .PRIO_RST(PRIO_RST)) u_fields (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .mode_a_pin_i (mode_a_pin_i),
      .mode_b_pin_i (mode_b_pin_i),
      .irq_mask_i   (irq_mask_i),
      .clr_spec_i   (clr_spec),
      .ld_a_i       (ld_a),
      .ld_vis_i     (ld_vis),
      .ld_prio_i    (ld_prio),
      .a_d_i        (wr_data_i[A_BIT]),
      .vis_d_i      (wr_data_i[VIS_BIT]),
      .prio_d_i     (wr_data_i[PRIO_W-1:0]),
      .boot_q_o     (boot_q),
      .spec_q_o     (spec_q),
      .a_q_o        (a_q),
      .vis_q_o      (vis_q),
      .prio_q_o     (prio_q)
   );

   opmode_rd_pack #(.DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_rd (
      .sel_i     (sel_i),
      .boot_i    (boot_q),
      .spec_i    (spec_q),
      .a_i       (a_q),
      .vis_i     (vis_q),
      .prio_i    (prio_q),
      .rd_data_o (rd_data_o)
   );

   assign mode_o        = opmode_decode(spec_q, a_q);
   assign boot_rom_en_o = boot_q;
   assign rd_vis_o      = vis_q;
   assign prio_sel_o    = prio_q;
endmodule

// File: tb/test_opmode_ctl_reg.sv
module test_opmode_ctl_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_a = 1'b0, pin_b = 1'b1, imask = 1'b0;
   logic       sel = 1'b0, wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [1:0] mode;
   logic       boot, vis;
   logic [3:0] prio;
   int         errors = 0, checks = 0;

   always #2.5 clk = ~clk;

   opmode_ctl_reg i_opmode_ctl_reg (
      .clk_i(clk), .rst_ni(rst_n), .mode_a_pin_i(pin_a), .mode_b_pin_i(pin_b),
      .irq_mask_i(imask), .sel_i(sel), .wr_en_i(wr), .wr_data_i(wdata),
      .rd_data_o(rdata), .mode_o(mode), .boot_rom_en_o(boot), .rd_vis_o(vis),
      .prio_sel_o(prio)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] exp);
      sel = 1'b1; #0.5;
      chk(tag, rdata, exp);
      sel = 1'b0; #0.5;
   endtask

   task automatic do_reset(input logic b, input logic a);
      @(negedge clk); rst_n = 1'b0; pin_b = ~b; pin_a = ~a;
      repeat (2) @(posedge clk);
      @(negedge clk); pin_b = b; pin_a = a;
      @(negedge clk); rst_n = 1'b1; pin_b = ~b; pin_a = ~a;
      #0.5;
   endtask

   task automatic bus_wr(input logic [7:0] d, input logic m);
      @(negedge clk); sel = 1'b1; wr = 1'b1; wdata = d; imask = m;
      @(posedge clk); #0.5; sel = 1'b0; wr = 1'b0; imask = 1'b0;
   endtask

   task automatic t_reset_modes();
      do_reset(1'b1, 1'b0);
      chk("R1 single mode", mode, 2'b00);
      chk("R6 boot off single", boot, 1'b0);
      chk("R7 prio reset", prio, 4'b0101);
      chk("R5 vis reset", vis, 1'b0);
      rd_chk("R10 read single", 8'h05);
      @(negedge clk); sel = 1'b0; #0.5;
      chk("R10 read unselected", rdata, 8'h00);
      repeat (3) @(posedge clk); #0.5;
      chk("R2 pins ignored after reset", mode, 2'b00);
      do_reset(1'b1, 1'b1);
      chk("R1 expanded mode", mode, 2'b01);
      rd_chk("R10 read expanded", 8'h25);
      do_reset(1'b0, 1'b0);
      chk("R1 bootstrap mode", mode, 2'b10);
      chk("R6 boot on bootstrap", boot, 1'b1);
      rd_chk("R10 read bootstrap", 8'hC5);
      do_reset(1'b0, 1'b1);
      chk("R2 last reset cycle latched", mode, 2'b11);
      chk("R6 boot off test", boot, 1'b0);
      rd_chk("R10 read test", 8'h65);
   endtask

   task automatic t_single_locked();
      do_reset(1'b1, 1'b0);
      bus_wr(8'hFF, 1'b1);
      chk("R3 special not set", mode[1], 1'b0);
      chk("R4 mode-A locked", mode[0], 1'b0);
      chk("R5 vis locked", vis, 1'b0);
      chk("R6 boot write ignored", boot, 1'b0);
      rd_chk("R10 read after locked write", 8'h0F);
   endtask

   task automatic t_prio_mask();
      do_reset(1'b1, 1'b0);
      bus_wr(8'h0F, 1'b1);
      bus_wr(8'h03, 1'b0);
      chk("R8 prio held unmasked", prio, 4'hF);
      bus_wr(8'h03, 1'b1);
      chk("R8 prio written masked", prio, 4'h3);
   endtask

   task automatic t_special_writes();
      do_reset(1'b0, 1'b0);
      bus_wr(8'h7A, 1'b1);
      chk("R4 mode-A written special", mode, 2'b11);
      chk("R5 vis written special", vis, 1'b1);
      chk("R6 boot kept on zero write", boot, 1'b1);
      rd_chk("R10 read special", 8'hFA);
      bus_wr(8'h40, 1'b0);
      rd_chk("R8 prio held, R4 a cleared", 8'hCA);
   endtask

   task automatic t_combined_clear();
      do_reset(1'b0, 1'b1);
      bus_wr(8'h35, 1'b1);
      chk("R3 special cleared", mode, 2'b01);
      chk("R9 vis pulse", vis, 1'b1);
      @(posedge clk); #0.5;
      chk("R9 vis back to 0", vis, 1'b0);
      bus_wr(8'h05, 1'b1);
      chk("R4 mode-A locked after clear", mode, 2'b01);
      rd_chk("R10 read after clear", 8'h25);
   endtask

   initial begin
      fork
         begin
            t_reset_modes();
            t_single_locked();
            t_prio_mask();
            t_special_writes();
            t_combined_clear();
         end
         begin
            repeat (5000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule